// File: doc/BRIEF.md
# Pipelined Half-Adder Array Adder

This block adds two unsigned 16-bit operands at full throughput. Instead of a ripple or lookahead carry chain, it resolves carries with a triangular array of half-adder rows. An entry stage first forms a bitwise sum and a generate vector. Each following half-adder row then folds the carry vector, shifted up one bit, into the running sum. Each register stage evaluates two such rows, so a carry moves two bit positions per clock. Sixteen rows are enough to settle any carry chain, which gives eight register stages.

Operands enter aligned on one clock edge, and the 17-bit result leaves aligned eight clocks later. A new pair may be presented on every cycle. A qualifying flag travels beside the data through a shift register of the same depth, so downstream logic knows which output cycles carry a real result.

The stage registers are a full word wide. Low-order sum bits finish early and ride along in them as deskew storage. The carry flops below the settled boundary are constant zero and drop out in synthesis.

Top module: `ha_array_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_sum` is 0.
- R2: When `out_valid` is 1, `out_sum` equals the exact unsigned sum `op_a + op_b`, zero-extended to 17 bits, of the pair captured eight rising edges earlier.
- R3: A single pair captured with `in_valid` = 1 on rising edge k makes `out_valid` high after rising edge k+7, that is, it can be sampled on edge k+8 (latency 8).
- R4: Pairs presented on consecutive cycles come out on consecutive cycles, in order, with no bubble and no loss.
- R5: Bit 16 of `out_sum` is the carry out and is 1 exactly when the sum reaches 0x10000. The largest result, 0xFFFF + 0xFFFF, is 0x1FFFE.
- R6: Sums with a full-length carry chain, such as 0xFFFF + 0x0001 = 0x10000, come out correct with the same eight-cycle latency.
- R7: A cycle with `in_valid` = 0 gives a cycle with `out_valid` = 0 eight cycles later, and gaps keep their positions in the stream.
- R8: A synchronous reset asserted while pairs are in flight discards them: no `out_valid` pulse appears for any pair captured before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand pair on this cycle as real |
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| out_valid | output | 1 | Marks `out_sum` as a real result |
| out_sum | output | 17 | Sum with the carry out in bit 16 |

## Verification
A table of fixed pairs covers several cases. Zero and small sums show that bits which settle in the entry stage are stored correctly. Alternating patterns such as 0xAAAA + 0x5555 give a long run of propagate bits with no carry. Pairs such as 0x0F0F + 0xF0F1 and 0xC350 + 0x3CB0 send a carry all the way to bit 16.

Directed cases test the worst-case chains 0xFFFF + 0x0001 and 0x0001 + 0xFFFF against the maximum sum. These separate a design that resolves all sixteen rows from one that stops a row short. A long back-to-back random stream shows that neighbouring pairs never mix. An isolated pulse measures the latency exactly. Gapped streams and a reset in the middle of a stream show that the valid flag stays in step with the data.

// File: rtl/ha_adder_pkg.sv
`timescale 1ns/1ps
package ha_adder_pkg;

    localparam int unsigned DEF_WIDTH          = 16;
    localparam int unsigned DEF_ROWS_PER_STAGE = 2;

    // Register stages needed so that stages * rows covers every carry hop.
    function automatic int unsigned stage_count(input int unsigned width,
                                                input int unsigned rows);
        return (width + rows - 1) / rows;
    endfunction

    // Total half-adder rows evaluated across the whole pipe.
    function automatic int unsigned total_rows(input int unsigned width,
                                               input int unsigned rows);
        return stage_count(width, rows) * rows;
    endfunction

endpackage

// File: rtl/ha_valid_pipe.sv
`timescale 1ns/1ps
module ha_valid_pipe #(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic v_in,
    output logic v_out
);
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr <= (sr << 1) | DEPTH'(v_in);
        end
    end

    assign v_out = sr[DEPTH-1];
endmodule

// File: rtl/ha_row_stage.sv
`timescale 1ns/1ps
// One register stage holding ROWS merged half-adder rows; forwards sum and carry.
module ha_row_stage #(
    parameter int unsigned W    = 17,
    parameter int unsigned ROWS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] c_in,
    output logic [W-1:0] s_q,
    output logic [W-1:0] c_q
);
    logic [W-1:0] s_row [ROWS+1];
    logic [W-1:0] c_row [ROWS+1];

    assign s_row[0] = s_in;
    assign c_row[0] = c_in;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign s_row[r+1] = s_row[r] ^ (c_row[r] << 1);
        assign c_row[r+1] = s_row[r] & (c_row[r] << 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
            c_q <= '0;
        end else begin
            s_q <= s_row[ROWS];
            c_q <= c_row[ROWS];
        end
    end
endmodule

// File: rtl/ha_final_stage.sv
`timescale 1ns/1ps
// Closing stage: its last row only needs the sum, as no carry can remain.
module ha_final_stage #(
    parameter int unsigned W    = 17,
    parameter int unsigned ROWS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] c_in,
    output logic [W-1:0] s_q
);
    logic [W-1:0] s_row [ROWS+1];
    logic [W-1:0] c_row [ROWS];

    assign s_row[0] = s_in;
    assign c_row[0] = c_in;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign s_row[r+1] = s_row[r] ^ (c_row[r] << 1);
        if (r < ROWS - 1) begin : g_cry
            assign c_row[r+1] = s_row[r] & (c_row[r] << 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_row[ROWS];
        end
    end
endmodule

// File: rtl/ha_array_adder.sv
`timescale 1ns/1ps
module ha_array_adder
    import ha_adder_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned ROWS  = DEF_ROWS_PER_STAGE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             out_valid,
    output logic [WIDTH:0]   out_sum
);
    localparam int unsigned SW     = WIDTH + 1;
    localparam int unsigned STAGES = stage_count(WIDTH, ROWS);

    // Inputs of each register stage: running sum and pending carry vector.
    logic [SW-1:0] s_at [STAGES];
    logic [SW-1:0] c_at [STAGES];

    // Entry: bitwise sum and generate vector, widened for the carry out.
    assign s_at[0] = {1'b0, op_a ^ op_b};
    assign c_at[0] = {1'b0, op_a & op_b};

    for (genvar i = 0; i < STAGES - 1; i++) begin : g_stage
        ha_row_stage #(.W(SW), .ROWS(ROWS)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .s_in (s_at[i]),
            .c_in (c_at[i]),
            .s_q  (s_at[i+1]),
            .c_q  (c_at[i+1])
        );
    end

    ha_final_stage #(.W(SW), .ROWS(ROWS)) u_final (
        .clk  (clk),
        .rst  (rst),
        .s_in (s_at[STAGES-1]),
        .c_in (c_at[STAGES-1]),
        .s_q  (out_sum)
    );

    ha_valid_pipe #(.DEPTH(STAGES)) u_vpipe (
        .clk   (clk),
        .rst   (rst),
        .v_in  (in_valid),
        .v_out (out_valid)
    );
endmodule

// File: rtl/ha_array_adder_chk.sv
`timescale 1ns/1ps
module ha_array_adder_chk #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             out_valid,
    input logic [WIDTH:0]   out_sum
);
    localparam int unsigned CW = $clog2(STAGES + 1);

    logic           ref_v [STAGES];
    logic [WIDTH:0] ref_s [STAGES];
    logic [CW-1:0]  since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                ref_v[i] <= 1'b0;
                ref_s[i] <= '0;
            end
            since_rst <= '0;
        end else begin
            ref_v[0] <= in_valid;
            ref_s[0] <= {1'b0, op_a} + {1'b0, op_b};
            for (int i = 1; i < STAGES; i++) begin
                ref_v[i] <= ref_v[i-1];
                ref_s[i] <= ref_s[i-1];
            end
            if (since_rst != CW'(STAGES)) since_rst <= since_rst + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sum == '0));

    assert_exact_sum_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_sum == ref_s[STAGES-1]);

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid == ref_v[STAGES-1]);

    assert_carry_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sum[WIDTH]) |-> out_sum[WIDTH-1:0] != '1);

    assert_flush_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(STAGES)) |-> !out_valid);
endmodule

bind ha_array_adder ha_array_adder_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/ha_array_adder_tb.sv
`timescale 1ns/1ps
module ha_array_adder_tb;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        out_valid;
    logic [16:0] out_sum;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R2";

    // Bench-side latency model: one entry per cycle of input.
    logic        h_v   [LAT];
    logic [16:0] h_s   [LAT];
    string       h_tag [LAT];
    logic [16:0] drv_exp = '0;

    // {a, b, expected 17-bit sum}
    localparam logic [48:0] TAB [12] = '{
        {16'h0000, 16'h0000, 17'h00000},
        {16'h0001, 16'h0001, 17'h00002},
        {16'h1234, 16'h4321, 17'h05555},
        {16'hFFFF, 16'h0000, 17'h0FFFF},
        {16'h00FF, 16'h0001, 17'h00100},
        {16'h0F0F, 16'hF0F1, 17'h10000},
        {16'hAAAA, 16'h5555, 17'h0FFFF},
        {16'hAAAA, 16'hAAAA, 17'h15554},
        {16'h7FFF, 16'h0001, 17'h08000},
        {16'hFFFE, 16'h0001, 17'h0FFFF},
        {16'h8000, 16'h7FFF, 17'h0FFFF},
        {16'hC350, 16'h3CB0, 17'h10000}
    };

    ha_array_adder u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                         input logic [16:0] e);
        @(posedge clk);
        #1;
        in_valid = v;
        op_a     = a;
        op_b     = b;
        drv_exp  = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 16'h0, 16'h0, 17'h0);
    endtask

    // Monitor: compare against the entry recorded LAT cycles ago, then shift.
    always @(negedge clk) begin
        if (chk_en) begin
            check(out_valid === h_v[LAT-1], h_tag[LAT-1], "out_valid",
                  32'(out_valid), 32'(h_v[LAT-1]));
            if (h_v[LAT-1])
                check(out_sum === h_s[LAT-1], h_tag[LAT-1], "out_sum",
                      32'(out_sum), 32'(h_s[LAT-1]));
        end
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                h_v[i] = 1'b0; h_s[i] = '0; h_tag[i] = "R8";
            end
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                h_v[i] = h_v[i-1]; h_s[i] = h_s[i-1]; h_tag[i] = h_tag[i-1];
            end
            h_v[0]   = in_valid;
            h_s[0]   = drv_exp;
            h_tag[0] = cur_req;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] x;
        int          n;
        int          seen;
        x = 32'h1234_5678;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
        check(out_sum == 17'h0, "R1", "out_sum in reset", 32'(out_sum), 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_sum == 17'h0, "R1", "first cycle after reset",
              {15'h0, out_valid, out_sum[15:0]}, 0);
        chk_en = 1'b1;

        // R2: table walked back to back
        cur_req = "R2";
        foreach (TAB[i]) drive(1'b1, TAB[i][48:33], TAB[i][32:17], TAB[i][16:0]);
        idle(LAT + 1);

        // R6: full-length carry chains
        cur_req = "R6";
        drive(1'b1, 16'hFFFF, 16'h0001, 17'h10000);
        drive(1'b1, 16'h0001, 16'hFFFF, 17'h10000);
        drive(1'b1, 16'h5555, 16'hAAAB, 17'h10000);
        idle(LAT + 1);

        // R5: carry-out boundary
        cur_req = "R5";
        drive(1'b1, 16'hFFFF, 16'hFFFF, 17'h1FFFE);
        drive(1'b1, 16'h8000, 16'h8000, 17'h10000);
        drive(1'b1, 16'h7FFF, 16'h8000, 17'h0FFFF);
        idle(LAT + 1);

        // R3: isolated pulse latency
        cur_req = "R3";
        drive(1'b1, 16'h0003, 16'h0004, 17'h00007);
        drive(1'b0, 16'h0, 16'h0, 17'h0);
        n = 1;
        @(negedge clk);
        while (!out_valid && n < 20) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check(n == LAT, "R3", "latency in edges", 32'(n), 32'(LAT));
        idle(LAT);

        // R4: random back-to-back stream
        cur_req = "R4";
        for (int i = 0; i < 200; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            drive(1'b1, x[31:16], x[15:0], {1'b0, x[31:16]} + {1'b0, x[15:0]});
        end
        idle(LAT + 1);

        // R7: gapped stream
        cur_req = "R7";
        for (int i = 0; i < 24; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            drive((i % 3) != 0, x[15:0], x[31:16], {1'b0, x[15:0]} + {1'b0, x[31:16]});
        end
        idle(LAT + 1);

        // R8: reset with pairs in flight
        cur_req = "R8";
        for (int i = 0; i < 5; i++) drive(1'b1, 16'h1000, 16'(i), 17'h01000 + 17'(i));
        @(posedge clk); #1; rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1; rst = 1'b0;
        seen = 0;
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, "R8", "valid pulses after flush", 32'(seen), 0);
        drive(1'b1, 16'hFFFF, 16'h0001, 17'h10000);
        idle(LAT + 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule